// File: doc/BRIEF.md
# Sharer-History Victim Selector

This block chooses which way of a set to evict in a cache bank that several processors share. Each line carries a short history register. Every access to the line shifts the accessing processor's ID into it, and the oldest entry falls out. When a processor asks for a victim in a set, the block compares the processor's ID against every valid cell of every way's history. It does this in one parallel pass, using a bitwise XOR that must give zero. A line whose full history names only the requester counts as that processor's own line, and it is evicted first. This keeps lines that several processors use in the shared bank.

When no way in the set qualifies, the block falls back to true LRU. Each set keeps a complete age ordering of its ways. An access or a fill moves a way to most-recently-used. A fill loads the filling processor's ID into every history cell of the line. The victim comes back one clock after the request, with a flag that tells whether the history rule or the LRU fallback chose it. Tags, data arrays and coherence live outside this block.

Top module: `shv_victim_sel`

## Requirements
- R1: An access shifts the accessing processor's ID into cell 0 of that line's history and moves every older cell one place deeper. The entry in the deepest cell (cell 3 by default) is discarded.
- R2: A way qualifies for a request from processor c only if every one of its HIST_DEPTH (default 4) cells is valid and holds exactly c.
- R3: After reset every history cell is invalid. An invalid cell never matches, so a line whose history is not yet full never qualifies.
- R4: When several ways of the addressed set qualify, the lowest-numbered way is returned.
- R5: When no way qualifies, the least-recently-used way of the set is returned and vic_by_history is 0. After reset the age order of every set is way 0 newest through way NUM_WAYS-1 oldest.
- R6: An access or a fill makes its way the most recently used way of its set. Ways that were newer than it each age by one. If an access and a fill hit the same set in one cycle, the access is applied first.
- R7: A fill writes the filling processor's ID into all history cells of the line and marks them valid. A fill overrides an access to the same line in the same cycle.
- R8: vic_valid is high in the cycle after each cycle in which evq_valid is high, and low otherwise. vic_by_history is 1 when the history rule chose the way. vic_valid is 0 out of reset.
- R9: An eviction request sees the history and age updates from accesses and fills that occur in the same cycle as the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access event strobe |
| acc_set | input | SET_W | Set of the accessed line |
| acc_way | input | WAY_W | Way of the accessed line |
| acc_cpu | input | ID_W | ID of the accessing processor |
| fill_valid | input | 1 | Fill event strobe |
| fill_set | input | SET_W | Set being filled |
| fill_way | input | WAY_W | Way being filled |
| fill_cpu | input | ID_W | ID of the filling processor |
| evq_valid | input | 1 | Eviction request strobe |
| evq_set | input | SET_W | Set to choose a victim in |
| evq_cpu | input | ID_W | ID of the requesting processor |
| vic_valid | output | 1 | Victim result strobe, one cycle after the request |
| vic_way | output | WAY_W | Chosen victim way |
| vic_by_history | output | 1 | 1 when the history rule chose the way, 0 for LRU |

## Verification
Directed cases cover five situations. A freshly reset set tells the invalid-cell rule apart from a plain ID compare. A line touched three and then four times by one processor shows exactly when the history fills. A foreign access shows that a single other ID disqualifies the line. Two filled lines with the same owner expose the lowest-way priority. Access, fill and request in one cycle show the update order. Random traffic then runs over a few sets with a small pool of processor IDs. The small pool makes history matches and LRU fallbacks both common, so errors in the age ordering show up quickly against the bench's model.

// File: rtl/shv_pkg.sv
package shv_pkg;
   typedef enum logic {
      SRC_LRU  = 1'b0,
      SRC_HIST = 1'b1
   } vic_src_e;
endpackage

// File: rtl/shv_hist_store.sv
module shv_hist_store #(
   parameter int NUM_SETS   = 16,
   parameter int NUM_WAYS   = 8,
   parameter int HIST_DEPTH = 4,
   parameter int SET_W      = 4,
   parameter int WAY_W      = 3,
   parameter int ID_W       = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                acc_valid,
   input  logic [SET_W-1:0]    acc_set,
   input  logic [WAY_W-1:0]    acc_way,
   input  logic [ID_W-1:0]     acc_cpu,
   input  logic                fill_valid,
   input  logic [SET_W-1:0]    fill_set,
   input  logic [WAY_W-1:0]    fill_way,
   input  logic [ID_W-1:0]     fill_cpu,
   input  logic [SET_W-1:0]    qry_set,
   input  logic [ID_W-1:0]     qry_cpu,
   output logic [NUM_WAYS-1:0] match_vec
);
   logic [ID_W-1:0] cell_q [NUM_SETS][NUM_WAYS][HIST_DEPTH];
   logic            live_q [NUM_SETS][NUM_WAYS][HIST_DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < NUM_SETS; s++)
            for (int w = 0; w < NUM_WAYS; w++)
               for (int d = 0; d < HIST_DEPTH; d++) begin
                  cell_q[s][w][d] <= '0;
                  live_q[s][w][d] <= 1'b0;
               end
      end else begin
         if (acc_valid) begin
            for (int d = HIST_DEPTH - 1; d > 0; d--) begin
               cell_q[acc_set][acc_way][d] <= cell_q[acc_set][acc_way][d-1];
               live_q[acc_set][acc_way][d] <= live_q[acc_set][acc_way][d-1];
            end
            cell_q[acc_set][acc_way][0] <= acc_cpu;
            live_q[acc_set][acc_way][0] <= 1'b1;
         end
         // fill written last so it overrides an access to the same line
         if (fill_valid) begin
            for (int d = 0; d < HIST_DEPTH; d++) begin
               cell_q[fill_set][fill_way][d] <= fill_cpu;
               live_q[fill_set][fill_way][d] <= 1'b1;
            end
         end
      end
   end

   for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
      always_comb begin
         match_vec[w] = 1'b1;
         for (int d = 0; d < HIST_DEPTH; d++) begin
            if (!live_q[qry_set][w][d] || (|(cell_q[qry_set][w][d] ^ qry_cpu)))
               match_vec[w] = 1'b0;
         end
      end
   end
endmodule

// File: rtl/shv_lru_store.sv
module shv_lru_store #(
   parameter int NUM_SETS = 16,
   parameter int NUM_WAYS = 8,
   parameter int SET_W    = 4,
   parameter int WAY_W    = 3
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      acc_valid,
   input  logic [SET_W-1:0]          acc_set,
   input  logic [WAY_W-1:0]          acc_way,
   input  logic                      fill_valid,
   input  logic [SET_W-1:0]          fill_set,
   input  logic [WAY_W-1:0]          fill_way,
   input  logic [SET_W-1:0]          qry_set,
   output logic [NUM_WAYS*WAY_W-1:0] qry_ages,
   output logic [WAY_W-1:0]          lru_way
);
   localparam int VEC_W = NUM_WAYS * WAY_W;
   localparam logic [WAY_W-1:0] OLDEST = WAY_W'(NUM_WAYS - 1);

   logic [VEC_W-1:0] age_q [NUM_SETS];

   function automatic logic [VEC_W-1:0] touch(input logic [VEC_W-1:0] a,
                                              input logic [WAY_W-1:0] w);
      logic [WAY_W-1:0] cur;
      logic [VEC_W-1:0] r;
      cur = a[w*WAY_W +: WAY_W];
      r   = a;
      for (int j = 0; j < NUM_WAYS; j++)
         if (a[j*WAY_W +: WAY_W] < cur)
            r[j*WAY_W +: WAY_W] = a[j*WAY_W +: WAY_W] + 1'b1;
      r[w*WAY_W +: WAY_W] = '0;
      return r;
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < NUM_SETS; s++)
            for (int w = 0; w < NUM_WAYS; w++)
               age_q[s][w*WAY_W +: WAY_W] <= WAY_W'(w);
      end else if (acc_valid && fill_valid && (acc_set == fill_set)) begin
         age_q[acc_set] <= touch(touch(age_q[acc_set], acc_way), fill_way);
      end else begin
         if (acc_valid)
            age_q[acc_set] <= touch(age_q[acc_set], acc_way);
         if (fill_valid)
            age_q[fill_set] <= touch(age_q[fill_set], fill_way);
      end
   end

   assign qry_ages = age_q[qry_set];

   always_comb begin
      lru_way = '0;
      for (int w = 0; w < NUM_WAYS; w++)
         if (qry_ages[w*WAY_W +: WAY_W] == OLDEST)
            lru_way = WAY_W'(w);
   end
endmodule

// File: rtl/shv_pick.sv
module shv_pick #(
   parameter int NUM_WAYS = 8,
   parameter int WAY_W    = 3
) (
   input  logic [NUM_WAYS-1:0] match_vec,
   input  logic [WAY_W-1:0]    lru_way,
   output logic [WAY_W-1:0]    pick_way,
   output shv_pkg::vic_src_e   pick_src
);
   logic [WAY_W-1:0] first_hit;

   always_comb begin
      first_hit = '0;
      for (int w = NUM_WAYS - 1; w >= 0; w--)
         if (match_vec[w])
            first_hit = WAY_W'(w);
   end

   assign pick_src = (|match_vec) ? shv_pkg::SRC_HIST : shv_pkg::SRC_LRU;
   assign pick_way = (|match_vec) ? first_hit : lru_way;
endmodule

// File: rtl/shv_victim_sel.sv
module shv_victim_sel #(
   parameter int NUM_SETS   = 16,
   parameter int NUM_WAYS   = 8,
   parameter int HIST_DEPTH = 4,
   parameter int NUM_CPUS   = 8,
   localparam int SET_W     = $clog2(NUM_SETS),
   localparam int WAY_W     = $clog2(NUM_WAYS),
   localparam int ID_W      = $clog2(NUM_CPUS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             acc_valid,
   input  logic [SET_W-1:0] acc_set,
   input  logic [WAY_W-1:0] acc_way,
   input  logic [ID_W-1:0]  acc_cpu,
   input  logic             fill_valid,
   input  logic [SET_W-1:0] fill_set,
   input  logic [WAY_W-1:0] fill_way,
   input  logic [ID_W-1:0]  fill_cpu,
   input  logic             evq_valid,
   input  logic [SET_W-1:0] evq_set,
   input  logic [ID_W-1:0]  evq_cpu,
   output logic             vic_valid,
   output logic [WAY_W-1:0] vic_way,
   output logic             vic_by_history
);
   if (NUM_WAYS < 2 || (NUM_WAYS & (NUM_WAYS - 1)) != 0) begin : g_bad_ways
      $error("NUM_WAYS must be a power of two of at least 2");
   end
   if (NUM_SETS < 2 || (NUM_SETS & (NUM_SETS - 1)) != 0) begin : g_bad_sets
      $error("NUM_SETS must be a power of two of at least 2");
   end
   if (NUM_CPUS < 2 || (NUM_CPUS & (NUM_CPUS - 1)) != 0) begin : g_bad_cpus
      $error("NUM_CPUS must be a power of two of at least 2");
   end
   if (HIST_DEPTH < 1) begin : g_bad_depth
      $error("HIST_DEPTH must be at least 1");
   end

   logic             req_q;
   logic [SET_W-1:0] req_set_q;
   logic [ID_W-1:0]  req_cpu_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q     <= 1'b0;
         req_set_q <= '0;
         req_cpu_q <= '0;
      end else begin
         req_q <= evq_valid;
         if (evq_valid) begin
            req_set_q <= evq_set;
            req_cpu_q <= evq_cpu;
         end
      end
   end

   logic [NUM_WAYS-1:0]       match_vec;
   logic [NUM_WAYS*WAY_W-1:0] set_ages;
   logic [WAY_W-1:0]          lru_way;
   logic [WAY_W-1:0]          pick_way;
   shv_pkg::vic_src_e         pick_src;

   shv_hist_store #(
      .NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS), .HIST_DEPTH(HIST_DEPTH),
      .SET_W(SET_W), .WAY_W(WAY_W), .ID_W(ID_W)
   ) u_hist (
      .clk(clk), .rst_n(rst_n),
      .acc_valid(acc_valid), .acc_set(acc_set), .acc_way(acc_way), .acc_cpu(acc_cpu),
      .fill_valid(fill_valid), .fill_set(fill_set), .fill_way(fill_way), .fill_cpu(fill_cpu),
      .qry_set(req_set_q), .qry_cpu(req_cpu_q),
      .match_vec(match_vec)
   );

   shv_lru_store #(
      .NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS), .SET_W(SET_W), .WAY_W(WAY_W)
   ) u_lru (
      .clk(clk), .rst_n(rst_n),
      .acc_valid(acc_valid), .acc_set(acc_set), .acc_way(acc_way),
      .fill_valid(fill_valid), .fill_set(fill_set), .fill_way(fill_way),
      .qry_set(req_set_q), .qry_ages(set_ages), .lru_way(lru_way)
   );

   shv_pick #(.NUM_WAYS(NUM_WAYS), .WAY_W(WAY_W)) u_pick (
      .match_vec(match_vec), .lru_way(lru_way),
      .pick_way(pick_way), .pick_src(pick_src)
   );

   assign vic_valid      = req_q;
   assign vic_way        = req_q ? pick_way : '0;
   assign vic_by_history = req_q && (pick_src == shv_pkg::SRC_HIST);
endmodule

// File: rtl/shv_victim_sel_chk.sv
module shv_victim_sel_chk #(
   parameter int NUM_WAYS = 8,
   parameter int WAY_W    = 3
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      evq_valid,
   input logic                      vic_valid,
   input logic [WAY_W-1:0]          vic_way,
   input logic                      vic_by_history,
   input logic [NUM_WAYS-1:0]       match_vec,
   input logic [NUM_WAYS*WAY_W-1:0] set_ages
);
   logic [NUM_WAYS-1:0] below_mask;
   logic [NUM_WAYS-1:0] newest_flags;
   logic [WAY_W-1:0]    vic_age;

   always_comb begin
      for (int j = 0; j < NUM_WAYS; j++) begin
         below_mask[j]   = (j < int'(vic_way));
         newest_flags[j] = (set_ages[j*WAY_W +: WAY_W] == '0);
      end
      vic_age = set_ages[vic_way*WAY_W +: WAY_W];
   end

   AST_RESP_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      evq_valid |=> vic_valid); // R8
   AST_NO_SPURIOUS_RESP: assert property (@(posedge clk) disable iff (!rst_n)
      !evq_valid |=> !vic_valid); // R8
   AST_HIST_WAY_QUALIFIES: assert property (@(posedge clk) disable iff (!rst_n)
      (vic_valid && vic_by_history) |-> match_vec[vic_way]); // R2
   AST_LOWEST_QUALIFIER: assert property (@(posedge clk) disable iff (!rst_n)
      (vic_valid && vic_by_history) |-> ((match_vec & below_mask) == '0)); // R4
   AST_FALLBACK_NO_QUALIFIER: assert property (@(posedge clk) disable iff (!rst_n)
      (vic_valid && !vic_by_history) |-> (match_vec == '0)); // R5
   AST_FALLBACK_OLDEST: assert property (@(posedge clk) disable iff (!rst_n)
      (vic_valid && !vic_by_history) |-> (vic_age == WAY_W'(NUM_WAYS - 1))); // R5
   AST_SINGLE_NEWEST: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot(newest_flags)); // R6
endmodule

bind shv_victim_sel shv_victim_sel_chk #(.NUM_WAYS(NUM_WAYS), .WAY_W(WAY_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .evq_valid(evq_valid),
   .vic_valid(vic_valid), .vic_way(vic_way), .vic_by_history(vic_by_history),
   .match_vec(match_vec), .set_ages(set_ages)
);

// File: tb/shv_victim_sel_test.sv
module shv_victim_sel_test;
   localparam int SETS = 16, WAYS = 8, DEPTH = 4, CPUS = 8;
   localparam int SW = 4, WW = 3, IW = 3;

   logic clk = 1'b0, rst_n = 1'b0;
   logic acc_valid = 0, fill_valid = 0, evq_valid = 0;
   logic [SW-1:0] acc_set = 0, fill_set = 0, evq_set = 0;
   logic [WW-1:0] acc_way = 0, fill_way = 0;
   logic [IW-1:0] acc_cpu = 0, fill_cpu = 0, evq_cpu = 0;
   logic vic_valid, vic_by_history;
   logic [WW-1:0] vic_way;

   always #4 clk = ~clk;

   shv_victim_sel #(.NUM_SETS(SETS), .NUM_WAYS(WAYS), .HIST_DEPTH(DEPTH), .NUM_CPUS(CPUS)) uut (
      .clk(clk), .rst_n(rst_n),
      .acc_valid(acc_valid), .acc_set(acc_set), .acc_way(acc_way), .acc_cpu(acc_cpu),
      .fill_valid(fill_valid), .fill_set(fill_set), .fill_way(fill_way), .fill_cpu(fill_cpu),
      .evq_valid(evq_valid), .evq_set(evq_set), .evq_cpu(evq_cpu),
      .vic_valid(vic_valid), .vic_way(vic_way), .vic_by_history(vic_by_history)
   );

   int m_cell [SETS][WAYS][DEPTH];
   bit m_live [SETS][WAYS][DEPTH];
   int m_age  [SETS][WAYS];
   int checks = 0, errors = 0;
   bit finished = 0;

   function automatic void model_reset();
      for (int s = 0; s < SETS; s++)
         for (int w = 0; w < WAYS; w++) begin
            m_age[s][w] = w;
            for (int d = 0; d < DEPTH; d++) begin
               m_cell[s][w][d] = 0;
               m_live[s][w][d] = 0;
            end
         end
   endfunction

   function automatic void model_touch(int s, int w);
      int cur = m_age[s][w];
      for (int j = 0; j < WAYS; j++)
         if (m_age[s][j] < cur) m_age[s][j]++;
      m_age[s][w] = 0;
   endfunction

   function automatic void model_access(int s, int w, int c);
      for (int d = DEPTH - 1; d > 0; d--) begin
         m_cell[s][w][d] = m_cell[s][w][d-1];
         m_live[s][w][d] = m_live[s][w][d-1];
      end
      m_cell[s][w][0] = c;
      m_live[s][w][0] = 1;
      model_touch(s, w);
   endfunction

   function automatic void model_fill(int s, int w, int c);
      for (int d = 0; d < DEPTH; d++) begin
         m_cell[s][w][d] = c;
         m_live[s][w][d] = 1;
      end
      model_touch(s, w);
   endfunction

   function automatic int model_pick(int s, int c, output bit by_hist);
      by_hist = 0;
      for (int w = 0; w < WAYS; w++) begin
         bit ok = 1;
         for (int d = 0; d < DEPTH; d++)
            if (!m_live[s][w][d] || m_cell[s][w][d] != c) ok = 0;
         if (ok) begin
            by_hist = 1;
            return w;
         end
      end
      for (int w = 0; w < WAYS; w++)
         if (m_age[s][w] == WAYS - 1) return w;
      return -1;
   endfunction

   task automatic chk(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // one cycle of stimulus; the model applies access, then fill, then picks
   task automatic step(bit a, int as, int aw, int ac,
                       bit f, int fs, int fw, int fc,
                       bit e, int es, int ec, string req);
      int  xw;
      bit  xh;
      @(negedge clk);
      acc_valid = a;  acc_set = SW'(as);  acc_way = WW'(aw);  acc_cpu = IW'(ac);
      fill_valid = f; fill_set = SW'(fs); fill_way = WW'(fw); fill_cpu = IW'(fc);
      evq_valid = e;  evq_set = SW'(es);  evq_cpu = IW'(ec);
      if (a) model_access(as, aw, ac);
      if (f) model_fill(fs, fw, fc);
      xw = 0; xh = 0;
      if (e) xw = model_pick(es, ec, xh);
      @(posedge clk);
      #2;
      chk(vic_valid == e, {req, " R8 valid"}, int'(vic_valid), int'(e));
      if (e) begin
         chk(int'(vic_way) == xw, {req, " way"}, int'(vic_way), xw);
         chk(vic_by_history == xh, {req, " R8 flag"}, int'(vic_by_history), int'(xh));
      end
   endtask

   task automatic idle();
      step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "idle");
   endtask

   initial begin
      #(8 * 150000);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int seed = 32'h5eed_1234;
      void'($urandom(seed));
      model_reset();
      repeat (3) @(posedge clk);
      #2;
      chk(vic_valid == 0, "R8 reset valid", int'(vic_valid), 0);
      @(negedge clk);
      rst_n = 1'b1;

      // R3 R5: fresh set, nothing valid -> oldest way by reset order
      step(0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, "R3 R5 fresh");
      chk(vic_way == WW'(WAYS - 1) && !vic_by_history, "R5 reset order", int'(vic_way), WAYS - 1);
      // R3: three accesses leave one cell invalid
      for (int k = 0; k < 3; k++) step(1, 1, 2, 3, 0, 0, 0, 0, 0, 0, 0, "R1 fillup");
      step(0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 3, "R3 partial");
      chk(!vic_by_history, "R3 partial history", int'(vic_by_history), 0);
      // R1 R9: fourth access with same-cycle request qualifies way 2
      step(1, 1, 2, 3, 0, 0, 0, 0, 1, 1, 3, "R9 same cycle");
      chk(vic_way == 3'd2 && vic_by_history, "R1 R9 full history", int'(vic_way), 2);
      // R1: one foreign access disqualifies the line
      step(1, 1, 2, 4, 0, 0, 0, 0, 1, 1, 3, "R1 foreign");
      chk(!vic_by_history, "R1 foreign id", int'(vic_by_history), 0);
      // R7 R4: two fills by the same processor, lowest wins
      step(0, 0, 0, 0, 1, 2, 5, 6, 0, 0, 0, "R7 fill");
      step(0, 0, 0, 0, 1, 2, 1, 6, 0, 0, 0, "R7 fill");
      step(0, 0, 0, 0, 0, 0, 0, 0, 1, 2, 6, "R4 tie");
      chk(vic_way == 3'd1 && vic_by_history, "R4 lowest way", int'(vic_way), 1);
      // R6: touching the two oldest ways makes way 5 the LRU
      step(1, 3, 7, 0, 0, 0, 0, 0, 0, 0, 0, "R6 touch");
      step(0, 0, 0, 0, 1, 3, 6, 1, 0, 0, 0, "R6 touch");
      step(0, 0, 0, 0, 0, 0, 0, 0, 1, 3, 2, "R6 order");
      chk(vic_way == 3'd5, "R6 lru after touches", int'(vic_way), 5);
      // R7 R9: access and fill on one line, fill wins, seen same cycle
      step(1, 4, 3, 1, 1, 4, 3, 2, 1, 4, 2, "R7 override");
      chk(vic_way == 3'd3 && vic_by_history, "R7 fill overrides access", int'(vic_way), 3);
      idle();

      // random traffic over few sets and processors
      for (int n = 0; n < 4000; n++) begin
         bit a = ($urandom % 4) != 0;
         bit f = ($urandom % 5) == 0;
         bit e = ($urandom % 3) == 0;
         step(a, $urandom % 3, $urandom % WAYS, $urandom % 2,
              f, $urandom % 3, $urandom % WAYS, $urandom % 2,
              e, $urandom % 3, $urandom % 2, "R2 R4 R5 R6 random");
      end
      idle();

      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule